// File: doc/BRIEF.md
# Parity-Syndrome Stop Decision for an Iterative LDPC Decoder

This block decides, after every decoding iteration, whether an iterative LDPC decoder may stop. The decoder hands it the hard-decision estimate of the whole n-bit codeword for the current iteration. The decoder forms each bit from the sign of its posterior value, with a negative value giving bit 1. For every row of a fixed binary parity-check matrix, the block XORs the hard bits in the columns where that row holds a 1. It then counts how many rows failed. A count of zero means the estimate is a valid codeword, so the block raises `done` and hands the word out. A nonzero count asks the decoder for another iteration, which starts again from variable-node processing.

An iteration limit bounds the decoding time. When the limit is reached and parity still fails, the block raises `done` together with `fail` and releases the last estimate. A `start` pulse at the beginning of every new codeword clears the iteration count and the stop state, and drops any evaluation still in flight. The parity-check matrix, the code length, the row count and the limit are all compile-time parameters.

The check is pipelined over three registers: row syndromes, then the failing-row count, then the decision. Every result therefore appears on the third rising edge after the hard-decision vector is accepted.

Top module: `synd_stop_check`

## Requirements
- R1: Row r of the matrix is the parameter slice `H[r*N +: N]`, where bit j is column j. That row's syndrome bit is the XOR of `hard_bits[j]` over every column j where the slice holds a 1.
- R2: Each accepted `hard_valid` produces a one-cycle `chk_valid` strobe exactly three rising edges later. `chk_weight` carries the number of rows whose syndrome bit is 1.
- R3: When the weight is zero, `done` rises and `fail` stays 0. In the same cycle, `word_valid` pulses for one cycle and `word_out` equals the evaluated hard-decision vector.
- R4: When the weight is nonzero and the iteration limit is not reached, `next_iter` pulses for one cycle. `done` and `word_valid` stay 0, and `word_out` keeps its previous value.
- R5: When the MAX_ITER-th evaluation since `start` has a nonzero weight, `done` and `fail` rise together. In the same cycle, `word_valid` pulses and `word_out` equals that last vector.
- R6: `iters` counts the evaluations completed since the last `start` and never exceeds MAX_ITER.
- R7: `start` clears `iters`, `done` and `fail` on the next rising edge and discards every evaluation in flight. A `hard_valid` in the same cycle as `start` is dropped.
- R8: While `done` is 1, `hard_valid` is ignored. No `chk_valid`, `next_iter` or `word_valid` strobe follows, and `iters` and `word_out` do not change.
- R9: After reset, every output is 0.
- R10: Once raised, `done` (and `fail` with it) holds until the next `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | New-codeword pulse |
| hard_valid | input | 1 | Hard-decision vector present for evaluation |
| hard_bits | input | N | Hard-decision bits, bit j is column j |
| chk_valid | output | 1 | Strobe: an evaluation result is present |
| chk_weight | output | $clog2(M+1) | Number of failing rows for that evaluation |
| next_iter | output | 1 | Strobe: run another iteration |
| done | output | 1 | Decoding finished (held until start) |
| fail | output | 1 | Finished at the limit without a valid codeword |
| word_valid | output | 1 | Strobe: word_out just latched, coincides with rising done |
| word_out | output | N | Released codeword estimate |
| iters | output | $clog2(MAX_ITER+1) | Evaluations completed since start |

## Verification
Every evaluation result (`chk_valid`, `chk_weight`, `next_iter`, `word_valid`, the rise of `done`/`fail` and the `iters` update) is due on the third rising edge after `hard_valid` is sampled. The effects of `start` are due on the first rising edge after it. The bench drives inputs on falling edges and samples on the falling edge that follows the edge where a result is due. This makes one-cycle strobes visible exactly once, and their absence can be checked in the same slot. An exhaustive sweep over all 4096 vectors of a 12-column, 6-row matrix compares the weight and the stop decision against values computed in the bench. Directed sequences then cover the iteration limit, the locking after `done`, flushing by `start`, and the same-cycle collision of `start` with `hard_valid`.

// File: rtl/synd_pkg.sv
package synd_pkg;

  // Outcome of one evaluation at the decision stage
  typedef enum logic [1:0] {
    DEC_NONE   = 2'd0,
    DEC_CONT   = 2'd1,
    DEC_PASS   = 2'd2,
    DEC_GIVEUP = 2'd3
  } decision_t;

endpackage

// File: rtl/synd_rows.sv
// Stage 1: per-row parity of the masked hard-decision vector.
module synd_rows #(
  parameter int N = 12,
  parameter int M = 6,
  parameter logic [M*N-1:0] H = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         flush,
  input  logic         in_valid,
  input  logic [N-1:0] bits_i,
  output logic         out_valid,
  output logic [M-1:0] syn_o,
  output logic [N-1:0] word_o
);

  logic [M-1:0] syn_d;

  // One XOR tree per matrix row
  for (genvar r = 0; r < M; r++) begin : g_row
    assign syn_d[r] = ^(bits_i & H[r*N +: N]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      syn_o     <= '0;
      word_o    <= '0;
    end else if (flush) begin
      out_valid <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        syn_o  <= syn_d;
        word_o <= bits_i;
      end
    end
  end

  AST_ROWS_FLUSHED: assert property (@(posedge clk) disable iff (rst)
    flush |=> !out_valid); // R7

endmodule

// File: rtl/synd_weight.sv
// Stage 2: count failing rows.
module synd_weight #(
  parameter int N = 12,
  parameter int M = 6,
  localparam int SW = $clog2(M + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          in_valid,
  input  logic [M-1:0]  syn_i,
  input  logic [N-1:0]  word_i,
  output logic          out_valid,
  output logic [SW-1:0] weight_o,
  output logic          zero_o,
  output logic [N-1:0]  word_o
);

  logic [SW-1:0] cnt;

  always_comb begin
    cnt = '0;
    for (int r = 0; r < M; r++) begin
      cnt = cnt + SW'(syn_i[r]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      weight_o  <= '0;
      zero_o    <= 1'b0;
      word_o    <= '0;
    end else if (flush) begin
      out_valid <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        weight_o <= cnt;
        zero_o   <= (syn_i == '0);
        word_o   <= word_i;
      end
    end
  end

  AST_WEIGHT_BOUND: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (weight_o <= SW'(M))); // R2

endmodule

// File: rtl/synd_term_ctrl.sv
// Stage 3: iteration counting and stop decision.
module synd_term_ctrl
  import synd_pkg::*;
#(
  parameter int N = 12,
  parameter int M = 6,
  parameter int MAX_ITER = 8,
  localparam int SW  = $clog2(M + 1),
  localparam int ITW = $clog2(MAX_ITER + 1)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic           in_valid,
  input  logic [SW-1:0]  weight_i,
  input  logic           zero_i,
  input  logic [N-1:0]   word_i,
  output logic           chk_valid,
  output logic [SW-1:0]  chk_weight,
  output logic           next_iter,
  output logic           done,
  output logic           fail,
  output logic           word_valid,
  output logic [N-1:0]   word_out,
  output logic [ITW-1:0] iters
);

  decision_t      dec;
  logic [ITW-1:0] iter_nxt;

  always_comb begin
    iter_nxt = iters + ITW'(1);
    dec      = DEC_NONE;
    if (in_valid && !done) begin
      if (zero_i)                          dec = DEC_PASS;
      else if (iter_nxt == ITW'(MAX_ITER)) dec = DEC_GIVEUP;
      else                                 dec = DEC_CONT;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      chk_valid  <= 1'b0;
      chk_weight <= '0;
      next_iter  <= 1'b0;
      done       <= 1'b0;
      fail       <= 1'b0;
      word_valid <= 1'b0;
      word_out   <= '0;
      iters      <= '0;
    end else if (start) begin
      chk_valid  <= 1'b0;
      next_iter  <= 1'b0;
      word_valid <= 1'b0;
      done       <= 1'b0;
      fail       <= 1'b0;
      iters      <= '0;
    end else begin
      chk_valid  <= (dec != DEC_NONE);
      next_iter  <= 1'b0;
      word_valid <= 1'b0;
      if (dec != DEC_NONE) begin
        chk_weight <= weight_i;
        iters      <= iter_nxt;
      end
      case (dec)
        DEC_CONT: next_iter <= 1'b1;
        DEC_PASS: begin
          done       <= 1'b1;
          word_valid <= 1'b1;
          word_out   <= word_i;
        end
        DEC_GIVEUP: begin
          done       <= 1'b1;
          fail       <= 1'b1;
          word_valid <= 1'b1;
          word_out   <= word_i;
        end
        default: ;
      endcase
    end
  end

  AST_FAIL_NEEDS_DONE: assert property (@(posedge clk) disable iff (rst)
    fail |-> done); // R5

  AST_ITER_LIMIT: assert property (@(posedge clk) disable iff (rst)
    iters <= ITW'(MAX_ITER)); // R6

  AST_CONT_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    next_iter |-> (!done && !word_valid)); // R4

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> done); // R10

  AST_VALID_ON_RISE: assert property (@(posedge clk) disable iff (rst)
    word_valid |-> (done && !$past(done))); // R3

  AST_LOCKED_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> $stable(iters)); // R8

endmodule

// File: rtl/synd_stop_check.sv
// Top: syndrome-based early-termination decision.
module synd_stop_check #(
  parameter int N = 12,
  parameter int M = 6,
  parameter logic [M*N-1:0] H = 72'h294_942_429_F00_0F0_00F,
  parameter int MAX_ITER = 8,
  localparam int SW  = $clog2(M + 1),
  localparam int ITW = $clog2(MAX_ITER + 1)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic           hard_valid,
  input  logic [N-1:0]   hard_bits,
  output logic           chk_valid,
  output logic [SW-1:0]  chk_weight,
  output logic           next_iter,
  output logic           done,
  output logic           fail,
  output logic           word_valid,
  output logic [N-1:0]   word_out,
  output logic [ITW-1:0] iters
);

  logic          accept;
  logic          s1_valid;
  logic [M-1:0]  s1_syn;
  logic [N-1:0]  s1_word;
  logic          s2_valid;
  logic [SW-1:0] s2_weight;
  logic          s2_zero;
  logic [N-1:0]  s2_word;

  assign accept = hard_valid && !start && !done;

  synd_rows #(.N(N), .M(M), .H(H)) u_rows (
    .clk       (clk),
    .rst       (rst),
    .flush     (start),
    .in_valid  (accept),
    .bits_i    (hard_bits),
    .out_valid (s1_valid),
    .syn_o     (s1_syn),
    .word_o    (s1_word)
  );

  synd_weight #(.N(N), .M(M)) u_weight (
    .clk       (clk),
    .rst       (rst),
    .flush     (start),
    .in_valid  (s1_valid),
    .syn_i     (s1_syn),
    .word_i    (s1_word),
    .out_valid (s2_valid),
    .weight_o  (s2_weight),
    .zero_o    (s2_zero),
    .word_o    (s2_word)
  );

  synd_term_ctrl #(.N(N), .M(M), .MAX_ITER(MAX_ITER)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .in_valid   (s2_valid),
    .weight_i   (s2_weight),
    .zero_i     (s2_zero),
    .word_i     (s2_word),
    .chk_valid  (chk_valid),
    .chk_weight (chk_weight),
    .next_iter  (next_iter),
    .done       (done),
    .fail       (fail),
    .word_valid (word_valid),
    .word_out   (word_out),
    .iters      (iters)
  );

  AST_STROBE_ORDER: assert property (@(posedge clk) disable iff (rst)
    chk_valid |-> (next_iter != word_valid)); // R2

endmodule

// File: tb/tb_synd_stop_check.sv
module tb_synd_stop_check;

  localparam int N = 12;
  localparam int M = 6;
  localparam int MAXI = 4;
  localparam logic [M*N-1:0] HB = 72'h294_942_429_F00_0F0_00F;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic hard_valid = 1'b0;
  logic [N-1:0] hard_bits = '0;
  logic chk_valid, next_iter, done, fail, word_valid;
  logic [2:0] chk_weight;
  logic [N-1:0] word_out;
  logic [2:0] iters;

  int n_tests = 0;
  int n_fail  = 0;

  always #4 clk = ~clk;

  synd_stop_check #(.N(N), .M(M), .H(HB), .MAX_ITER(MAXI)) dut (
    .clk(clk), .rst(rst), .start(start), .hard_valid(hard_valid),
    .hard_bits(hard_bits), .chk_valid(chk_valid), .chk_weight(chk_weight),
    .next_iter(next_iter), .done(done), .fail(fail), .word_valid(word_valid),
    .word_out(word_out), .iters(iters)
  );

  function automatic int exp_weight(input logic [N-1:0] w);
    int c = 0;
    for (int r = 0; r < M; r++) c += int'(^(w & HB[r*N +: N]));
    return c;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic pulse_start();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // Result is due on the third rising edge; sample on the falling edge after it
  task automatic push(input logic [N-1:0] w);
    hard_valid = 1'b1;
    hard_bits  = w;
    @(negedge clk);
    hard_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    summary();
  end

  initial begin
    int bad;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9: reset state
    check({chk_valid, next_iter, done, fail, word_valid} == 5'b0 && word_out == '0 && iters == '0,
          "R9 reset outputs", int'({done, fail, word_valid, iters}), 0);

    // R1 R2 R3 R4: exhaustive sweep, one iteration per codeword
    bad = 0;
    for (int w = 0; w < (1 << N); w++) begin
      int ew;
      pulse_start();
      push(N'(w));
      ew = exp_weight(N'(w));
      if (!(chk_valid && int'(chk_weight) == ew)) begin
        bad++;
        check(0, "R1 R2 weight", int'(chk_weight), ew);
      end
      if (done != (ew == 0) || next_iter != (ew != 0) || word_valid != (ew == 0)) begin
        bad++;
        check(0, "R3 R4 decision", int'({done, next_iter, word_valid}), (ew == 0) ? 5 : 2);
      end
      if (ew == 0 && word_out != N'(w)) begin
        bad++;
        check(0, "R3 word_out", int'(word_out), w);
      end
      if (fail) begin
        bad++;
        check(0, "R3 fail low", 1, 0);
      end
    end
    check(bad == 0, "R1 R2 R3 sweep mismatches", bad, 0);

    // R3: all-ones is a codeword of this matrix
    pulse_start();
    push(12'hFFF);
    check(done && !fail && word_valid && word_out == 12'hFFF, "R3 pass word",
          int'(word_out), 12'hFFF);
    // R10: done held over idle cycles, strobe gone
    repeat (5) @(negedge clk);
    check(done && !word_valid, "R10 done held", int'({done, word_valid}), 2);

    // R4: failing vector keeps previous word_out, single-bit flip hits two rows
    pulse_start();
    check(!done && !fail && iters == 0, "R7 start clears", int'({done, fail, iters}), 0);
    push(12'hFFE);
    check(next_iter && !done && chk_weight == 3'd2, "R4 continue", int'(chk_weight), 2);
    check(word_out == 12'hFFF && !word_valid, "R4 word_out unchanged", int'(word_out), 12'hFFF);
    check(iters == 1, "R6 iters after one", int'(iters), 1);

    // R5: limit reached with failing parity
    push(12'hFFE);
    push(12'h0F1);
    check(iters == 3 && next_iter, "R6 iters after three", int'(iters), 3);
    push(12'h0F1);
    check(done && fail && word_valid && word_out == 12'h0F1, "R5 give up", int'(word_out), 12'h0F1);
    check(iters == MAXI && !next_iter, "R5 R6 iters at limit", int'(iters), MAXI);

    // R8: input ignored after done
    push(12'h000);
    check(!chk_valid && !word_valid && !next_iter, "R8 no strobes", int'({chk_valid, word_valid}), 0);
    check(iters == MAXI && word_out == 12'h0F1 && done && fail, "R8 state kept", int'(word_out), 12'h0F1);

    // R7: start clears, then pass on second iteration
    pulse_start();
    check(!done && !fail && iters == 0, "R7 clear after limit", int'({done, fail, iters}), 0);
    push(12'hFFE);
    push(12'hFFF);
    check(done && !fail && iters == 2 && word_out == 12'hFFF, "R3 R6 pass at two",
          int'(iters), 2);

    // R7: hard_valid in the same cycle as start is dropped
    start = 1'b1;
    hard_valid = 1'b1;
    hard_bits = 12'hFFF;
    @(negedge clk);
    start = 1'b0;
    hard_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check(!chk_valid && !done && iters == 0, "R7 same-cycle drop", int'({chk_valid, done, iters}), 0);

    // R7: start flushes an evaluation in flight
    hard_valid = 1'b1;
    hard_bits = 12'hFFF;
    @(negedge clk);
    hard_valid = 1'b0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    check(!chk_valid && !done && iters == 0, "R7 flush in flight", int'({chk_valid, done}), 0);
    repeat (3) @(negedge clk);
    check(!done && iters == 0, "R7 flush stays clear", int'(iters), 0);

    summary();
  end

endmodule